// File: doc/BRIEF.md
# Delayed Coincidence Window Matcher

This block runs on the bunch-crossing clock, where one crossing lasts 25 ns and every delay and width is a whole number of crossings. It delays a reference strobe by a programmable number of crossings and opens a coincidence window of programmable width around the delayed strobe. When a second strobe, the candidate, lands inside that window, the block raises a one-crossing match flag. With that flag it reports the position inside the window where the hit fell. One typical use is matching a trigger accept against a data-available flag, where a successful match starts readout of the associated data. Another is pairing two trigger primitives.

Typical settings are as follows. Primitive pairing uses a delay of 8 with width 3. Accept matching uses a delay of 128 (0x80) with width 3. Front-end flag matching uses a delay of 116 with width 3. Data-available checks use delays of 0x18, 4 and 0x15 with width 2.

The window controller is a two-state machine with states WIN_IDLE and WIN_OPEN.
- START moves WIN_IDLE to WIN_OPEN when a window opens with no hit and the width is above 1.
- INSTANT stays in WIN_IDLE and reports a match when the hit arrives in the window's first crossing.
- SINGLE stays in WIN_IDLE when a one-crossing window passes with no hit.
- HIT moves WIN_OPEN to WIN_IDLE and reports a match.
- EXPIRE moves WIN_OPEN to WIN_IDLE after the last window crossing passes with no hit.
- ADVANCE stays in WIN_OPEN and steps the window position.

Top module: `coinc_window_matcher`

## Requirements
- R1: A reference strobe sampled in crossing t becomes the delayed strobe in crossing t+D, where D is `cfg_delay`. With width 1 the window is exactly crossing t+D. `match` is high in the crossing after the one in which the matching candidate was sampled.
- R2: For an odd width W, the window covers crossings t+D-(W-1)/2 through t+D+(W-1)/2.
- R3: For an even width W, the window covers crossings t+D-(W/2-1) through t+D+W/2. This places one more crossing after the delayed strobe than before it.
- R4: `match_pos` equals the candidate's crossing minus the window's first crossing, counted from 0. It is 0 whenever `match` is low.
- R5: Only the earliest candidate inside a window produces a match. Once reported, the window is closed and later candidates in its span are ignored.
- R6: A delayed strobe that arrives while a window is still open is ignored. One that arrives in the crossing after a window closes opens a new window.
- R7: Delays from 0 to 255 crossings are supported, including 116, 128 and 255.
- R8: A width setting of 0 behaves as a width of 1. The width range is 1 to 15.
- R9: When D is smaller than the early part of the window, the window starts in crossing t rather than before it.
- R10: During and just after reset, `match` and `match_pos` are 0 and the delay line is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_a | input | 1 | Reference strobe, delayed to place the window |
| strobe_b | input | 1 | Candidate strobe tested against the window |
| cfg_delay | input | 8 | Delay in crossings (0 to 255) |
| cfg_width | input | 4 | Window width in crossings (0 treated as 1) |
| match | output | 1 | One-crossing pulse on a coincidence |
| match_pos | output | 4 | Position of the hit inside the window |

## Verification
On every cycle the assertions check several properties. A match always follows a sampled candidate. The position stays zero when there is no match and stays below the width in force when the candidate was sampled. The controller is idle whenever a match is reported, so the window is consumed. A one-crossing delay reproduces the previous input. Only the bench scenarios can show where the window actually lands for a given delay and width: odd centring, even skew and clamping at short delays. The same holds for long delays, for the earliest-candidate rule and for the fate of a reference strobe arriving while a window is open. For each of these the bench compares the exact crossing and position of every match against its own window model.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
    typedef enum logic [0:0] {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;
endpackage

// File: rtl/cwm_delay_line.sv
module cwm_delay_line #(
    parameter int DEPTH = 256,
    localparam int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             tap
);
    logic [DEPTH-2:0] stage;

    for (genvar k = 0; k < DEPTH - 1; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= 1'b0;
                else        stage[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (!rst_n) stage[k] <= 1'b0;
                else        stage[k] <= stage[k-1];
            end
        end
    end

    always_comb begin
        if (tap_sel == '0) tap = din;
        else               tap = stage[tap_sel - 1'b1];
    end

    // R1: with a one-crossing tap, the output repeats the previous input
    a_r1_tap_unit: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && tap_sel == SEL_W'(1) && $past(tap_sel) == SEL_W'(1))
            |-> (tap == $past(din)));
endmodule

// File: rtl/cwm_window_fsm.sv
module cwm_window_fsm
    import cwm_pkg::*;
#(
    parameter int WB = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open_i,
    input  logic          hit_i,
    input  logic [WB-1:0] width_i,
    output logic          match_o,
    output logic [WB-1:0] pos_o
);
    win_state_e    state, state_n;
    logic [WB-1:0] cnt, cnt_n;
    logic          match_n;
    logic [WB-1:0] pos_n;
    logic [WB-1:0] last_pos;

    assign last_pos = width_i - WB'(1);

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        match_n = 1'b0;
        pos_n   = '0;
        unique case (state)
            WIN_IDLE: begin
                if (open_i) begin
                    if (hit_i) begin                // INSTANT
                        match_n = 1'b1;
                    end else if (last_pos != '0) begin  // START
                        state_n = WIN_OPEN;
                        cnt_n   = WB'(1);
                    end                             // SINGLE otherwise
                end
            end
            WIN_OPEN: begin
                if (hit_i) begin                    // HIT
                    match_n = 1'b1;
                    pos_n   = cnt;
                    state_n = WIN_IDLE;
                end else if (cnt >= last_pos) begin // EXPIRE
                    state_n = WIN_IDLE;
                end else begin                      // ADVANCE
                    cnt_n = cnt + WB'(1);
                end
            end
            default: state_n = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WIN_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_o <= 1'b0;
            pos_o   <= '0;
        end else begin
            match_o <= match_n;
            pos_o   <= pos_n;
        end
    end

    a_r1_match_needs_b: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(hit_i));
    a_r4_pos_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !match_o |-> (pos_o == '0));
    a_r4_pos_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (pos_o < $past(width_i)));
    a_r5_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (state == WIN_IDLE));
endmodule

// File: rtl/coinc_window_matcher.sv
module coinc_window_matcher #(
    parameter int DEPTH = 256,
    parameter int WB    = 4,
    localparam int DB   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_a,
    input  logic          strobe_b,
    input  logic [DB-1:0] cfg_delay,
    input  logic [WB-1:0] cfg_width,
    output logic          match,
    output logic [WB-1:0] match_pos
);
    logic [WB-1:0] width_eff;
    logic [WB-1:0] early;
    logic [DB-1:0] start_dly;
    logic          open_now;

    assign width_eff = (cfg_width == '0) ? WB'(1) : cfg_width;
    assign early     = (width_eff - WB'(1)) >> 1;
    assign start_dly = (cfg_delay >= DB'(early)) ? (cfg_delay - DB'(early)) : '0;

    cwm_delay_line #(.DEPTH(DEPTH)) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (strobe_a),
        .tap_sel (start_dly),
        .tap     (open_now)
    );

    cwm_window_fsm #(.WB(WB)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .open_i  (open_now),
        .hit_i   (strobe_b),
        .width_i (width_eff),
        .match_o (match),
        .pos_o   (match_pos)
    );
endmodule

// File: tb/coinc_window_matcher_test.sv
module coinc_window_matcher_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe_a = 1'b0;
    logic       strobe_b = 1'b0;
    logic [7:0] cfg_delay = 8'd8;
    logic [3:0] cfg_width = 4'd1;
    logic       match;
    logic [3:0] match_pos;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int seen = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    pos;
        string tag;
    } exp_t;
    exp_t q[$];

    coinc_window_matcher uut (
        .clk(clk), .rst_n(rst_n), .strobe_a(strobe_a), .strobe_b(strobe_b),
        .cfg_delay(cfg_delay), .cfg_width(cfg_width),
        .match(match), .match_pos(match_pos)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops the scoreboard as matches appear
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (match) begin
                seen++;
                total++;
                if (q.size() == 0) begin
                    bad++;
                    $display("FAIL R5: unexpected match at %0d pos=%0d (expected none)", cyc, match_pos);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.at != cyc || int'(match_pos) != e.pos) begin
                        bad++;
                        $display("FAIL %s: match at %0d pos=%0d, expected at %0d pos=%0d",
                                 e.tag, cyc, match_pos, e.at, e.pos);
                    end
                end
            end else if (match_pos != 4'd0) begin
                total++;
                bad++;
                $display("FAIL R4: pos=%0d while match low, expected 0", match_pos);
            end
            if (q.size() > 0 && q[0].at < cyc) begin
                exp_t m;
                m = q.pop_front();
                total++;
                bad++;
                $display("FAIL %s: no match at %0d, expected pos=%0d", m.tag, m.at, m.pos);
            end
        end
    end

    task automatic step(input bit a, input bit b);
        @(negedge clk);
        strobe_a = a;
        strobe_b = b;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // reference at rel 0 (and optionally a2), candidates at b0 < b1 (-1 = none)
    task automatic shot(input int d, input int w, input int b0, input int b1,
                        input int a2, input string tag);
        int we, early, s, e1, base, nexp, seen0;
        int bl[2];
        int mb[2];
        int mp[2];
        we    = (w == 0) ? 1 : w;
        early = (we - 1) / 2;
        s     = (d >= early) ? d - early : 0;
        bl[0] = b0;
        bl[1] = b1;
        nexp  = 0;
        e1    = s + we - 1;
        for (int i = 0; i < 2; i++) begin
            if (nexp == 0 && bl[i] >= s && bl[i] <= s + we - 1) begin
                mb[0] = bl[i]; mp[0] = bl[i] - s; nexp = 1; e1 = bl[i];
            end
        end
        if (a2 > 0 && s + a2 > e1) begin
            for (int i = 0; i < 2; i++) begin
                if (nexp < 2 && bl[i] >= s + a2 && bl[i] <= s + a2 + we - 1
                    && (nexp == 0 || bl[i] > mb[0])) begin
                    mb[nexp] = bl[i]; mp[nexp] = bl[i] - s - a2; nexp++;
                end
            end
        end
        cfg_delay = 8'(d);
        cfg_width = 4'(w);
        seen0 = seen;
        base  = 0;
        for (int i = 0; i < 268; i++) begin
            step(i == 0 || (a2 > 0 && i == a2), i == b0 || i == b1);
            if (i == 0) begin
                base = cyc;
                for (int k = 0; k < nexp; k++) q.push_back('{base + mb[k] + 1, mp[k], tag});
            end
        end
        check(seen - seen0 == nexp, {tag, " match count"}, seen - seen0, nexp);
    endtask

    initial begin
        #(10 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        strobe_a = 1'b1;
        repeat (4) @(negedge clk);
        check(match == 1'b0, "R10 match in reset", int'(match), 0);
        strobe_a = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(match == 1'b0 && match_pos == 4'd0, "R10 after reset", int'(match_pos), 0);
        repeat (260) step(1'b0, 1'b0);
        check(seen == 0, "R10 delay line empty", seen, 0);

        shot(8,   1, 8,   -1, -1, "R1");
        shot(8,   1, 7,    9, -1, "R1");
        shot(8,   3, 7,   -1, -1, "R2");
        shot(8,   3, 9,   -1, -1, "R2");
        shot(8,   3, 6,   10, -1, "R2");
        shot(4,   2, 3,    5, -1, "R3");
        shot(4,   2, 6,   -1, -1, "R3");
        shot(21, 15, 28,  -1, -1, "R4");
        shot(24,  2, 24,  25, -1, "R5");
        shot(8,   3, 7,    8, -1, "R5");
        shot(8,   3, 11,  -1,  2, "R6");
        shot(8,   3, 11,  -1,  3, "R6");
        shot(128, 3, 129, -1, -1, "R7");
        shot(116, 3, 115, -1, -1, "R7");
        shot(255, 1, 255, -1, -1, "R7");
        shot(4,   0, 4,   -1, -1, "R8");
        shot(4,   0, 3,    5, -1, "R8");
        shot(0,   3, 0,   -1, -1, "R9");
        shot(1,   5, 4,   -1, -1, "R9");

        check(q.size() == 0, "R5 scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule